// File: doc/BRIEF.md
# T1 Channel Substitution and Zero-Stuffing Stage

This block sits in the transmit path of a T1 framer and processes one channel byte per valid cycle. Each byte comes from the backplane with its channel index (0 to 23) and a strobe that marks the first byte of a frame. A 24-bit select mask names the channels whose bytes are replaced. A mode bit chooses the replacement:

- In idle mode, the replacement is one programmable 8-bit idle code, shared by all selected channels.
- In loopback mode, the replacement is the byte of the same channel received from the line. That byte is presented in step with the transmit byte.

After the substitution, a zero-suppression stage forces bit position 1 high in any all-zero byte. A 24-bit transparency mask exempts individual channels from that stage.

Software programs the block through a small write port. Mask, code and mode changes are held in shadow registers and take effect only at a frame-start strobe, so a frame is never partly changed. A monitor register keeps the last line byte received on a chosen channel, so loopback data can be inspected.

Top module: `t1_chan_sub`

## Requirements
- R1: After reset, out_valid is 0, mon_byte is 0, both masks and the mode bit are 0, and the monitor channel is 0. Data then passes unchanged apart from zero stuffing.
- R2: out_valid, out_ch and out_byte appear exactly one clock after in_valid, in_ch and in_byte.
- R3: A channel whose select-mask bit is 0 outputs its backplane byte unchanged, except for zero stuffing.
- R4: With mode 0, a selected channel outputs the idle code (write address 0, bits 7:0).
- R5: With mode 1 (write address 3, bit 0), a selected channel outputs the rx_byte presented in the same cycle.
- R6: Zero stuffing turns a final byte of 0x00 on a non-transparent channel into 0x02. It applies to substituted bytes as well. All other values pass unchanged.
- R7: A channel whose transparency-mask bit is set (write address 2, bit n for channel n) is never stuffed.
- R8: Writes to addresses 0 to 3 go to shadow registers. They are applied at the next cycle with in_valid and in_fs both high, and that strobed byte already uses the new values. The select mask is written at address 1, bit n for channel n.
- R9: mon_byte holds the last rx_byte that arrived with in_valid on the monitor channel (write address 4, bits 4:0, effective immediately). mon_byte[7] is the first bit on the line.
- R10: A byte with a channel index of 24 or more is never substituted and is treated as non-transparent.
- R11: Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_fs | input | 1 | Frame-start strobe, qualified by in_valid |
| in_ch | input | 5 | Channel index of the input byte |
| in_byte | input | 8 | Backplane byte, MSB first on the line |
| rx_byte | input | 8 | Line-side byte of the same channel |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 24 | Configuration write data |
| out_valid | output | 1 | Output byte valid |
| out_ch | output | 5 | Channel index of the output byte |
| out_byte | output | 8 | Substituted and stuffed byte |
| mon_byte | output | 8 | Last line byte seen on the monitor channel |

## Verification
The bound checker watches the following on every cycle:
- the one-cycle alignment of valid, channel and byte;
- that no zero byte leaves the block on a non-transparent channel;
- idle and loopback substitution of non-zero bytes, and pass-through of out-of-range channels;
- that the active configuration changes only right after a frame-start strobe.

Only the bench scenarios can show the following:
- the shadow-to-active timing of writes made mid-frame;
- the zero-byte corner cases for idle code and looped-back data;
- that writes to unused addresses have no effect;
- the monitor register contents and its channel selection.

// File: rtl/t1_sub_pkg.sv
package t1_sub_pkg;
    localparam int NUM_CH    = 24;
    localparam int BYTE_W    = 8;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = NUM_CH;
    localparam int STUFF_BIT = 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CH_W-1:0]   ch_t;
    typedef logic [NUM_CH-1:0] mask_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_IDLE = 3'd0,
        REG_SEL  = 3'd1,
        REG_XPAR = 3'd2,
        REG_MODE = 3'd3,
        REG_MON  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        byte_t idle;
        mask_t sel;
        mask_t xpar;
        logic  loop;
    } cfg_t;

    typedef struct packed {
        logic  valid;
        ch_t   ch;
        byte_t data;
    } lane_t;

    function automatic logic mask_hit(mask_t m, ch_t ch);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_CH; i++)
            if (ch == ch_t'(i)) hit = m[i];
        return hit;
    endfunction

    function automatic byte_t zero_stuff(byte_t b, logic exempt);
        byte_t r;
        r = b;
        if (!exempt && b == '0) r[STUFF_BIT] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/t1_sub_cfg.sv
module t1_sub_cfg
    import t1_sub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              commit,
    output cfg_t              eff_cfg,
    output cfg_t              act_cfg,
    output ch_t               mon_sel
);
    cfg_t shadow_q, active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            mon_sel  <= '0;
        end else begin
            if (commit) active_q <= shadow_q;
            if (cfg_we) begin
                case (reg_addr_e'(cfg_addr))
                    REG_IDLE: shadow_q.idle <= cfg_wdata[BYTE_W-1:0];
                    REG_SEL:  shadow_q.sel  <= cfg_wdata[NUM_CH-1:0];
                    REG_XPAR: shadow_q.xpar <= cfg_wdata[NUM_CH-1:0];
                    REG_MODE: shadow_q.loop <= cfg_wdata[0];
                    REG_MON:  mon_sel       <= cfg_wdata[CH_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    assign eff_cfg = commit ? shadow_q : active_q;
    assign act_cfg = active_q;
endmodule

// File: rtl/t1_sub_path.sv
module t1_sub_path
    import t1_sub_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t in_lane,
    input  byte_t rx_byte,
    input  cfg_t  cfg,
    output logic  sel_hit,
    output logic  xpar_hit,
    output lane_t out_lane
);
    byte_t picked;

    always_comb begin
        sel_hit  = mask_hit(cfg.sel, in_lane.ch);
        xpar_hit = mask_hit(cfg.xpar, in_lane.ch);
        if (!sel_hit)      picked = in_lane.data;
        else if (cfg.loop) picked = rx_byte;
        else               picked = cfg.idle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_lane <= '0;
        end else begin
            out_lane.valid <= in_lane.valid;
            out_lane.ch    <= in_lane.ch;
            out_lane.data  <= zero_stuff(picked, xpar_hit);
        end
    end
endmodule

// File: rtl/t1_sub_mon.sv
module t1_sub_mon
    import t1_sub_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  ch_t   in_ch,
    input  ch_t   mon_sel,
    input  byte_t rx_byte,
    output byte_t mon_byte
);
    always_ff @(posedge clk) begin
        if (rst)                              mon_byte <= '0;
        else if (in_valid && in_ch == mon_sel) mon_byte <= rx_byte;
    end
endmodule

// File: rtl/t1_chan_sub.sv
module t1_chan_sub
    import t1_sub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_fs,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_ch,
    output logic [BYTE_W-1:0] out_byte,
    output logic [BYTE_W-1:0] mon_byte
);
    cfg_t  eff_cfg, act_cfg;
    ch_t   mon_sel;
    lane_t in_lane, out_lane;
    logic  commit, sel_hit, xpar_hit;

    assign commit  = in_valid && in_fs;
    assign in_lane = '{valid: in_valid, ch: in_ch, data: in_byte};

    t1_sub_cfg u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .commit(commit), .eff_cfg(eff_cfg),
        .act_cfg(act_cfg), .mon_sel(mon_sel)
    );

    t1_sub_path u_path (
        .clk(clk), .rst(rst), .in_lane(in_lane), .rx_byte(rx_byte),
        .cfg(eff_cfg), .sel_hit(sel_hit), .xpar_hit(xpar_hit),
        .out_lane(out_lane)
    );

    t1_sub_mon u_mon (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch),
        .mon_sel(mon_sel), .rx_byte(rx_byte), .mon_byte(mon_byte)
    );

    assign out_valid = out_lane.valid;
    assign out_ch    = out_lane.ch;
    assign out_byte  = out_lane.data;
endmodule

// File: rtl/t1_chan_sub_chk.sv
module t1_chan_sub_chk
    import t1_sub_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  in_valid,
    input logic  in_fs,
    input ch_t   in_ch,
    input byte_t in_byte,
    input byte_t rx_byte,
    input logic  out_valid,
    input ch_t   out_ch,
    input byte_t out_byte,
    input logic  sel_hit,
    input logic  xpar_hit,
    input cfg_t  eff_cfg,
    input cfg_t  act_cfg
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        out_valid == $past(in_valid));
    // R2
    ch_delay_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        out_valid |-> out_ch == $past(in_ch));
    // R6
    no_zero_out_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        (out_valid && out_byte == '0) |-> $past(xpar_hit));
    // R4
    idle_sub_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        $past(in_valid && sel_hit && !eff_cfg.loop && eff_cfg.idle != '0)
        |-> out_byte == $past(eff_cfg.idle));
    // R5
    loop_sub_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        $past(in_valid && sel_hit && eff_cfg.loop && rx_byte != '0)
        |-> out_byte == $past(rx_byte));
    // R10
    range_pass_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        $past(in_valid && in_ch >= ch_t'(NUM_CH) && in_byte != '0)
        |-> out_byte == $past(in_byte));
    // R8
    frame_commit_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        !$stable(act_cfg) |-> $past(in_valid && in_fs));
endmodule

bind t1_chan_sub t1_chan_sub_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fs(in_fs), .in_ch(in_ch),
    .in_byte(in_byte), .rx_byte(rx_byte), .out_valid(out_valid),
    .out_ch(out_ch), .out_byte(out_byte), .sel_hit(sel_hit),
    .xpar_hit(xpar_hit), .eff_cfg(eff_cfg), .act_cfg(act_cfg)
);

// File: tb/test_t1_chan_sub.sv
module test_t1_chan_sub;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 0, in_fs = 0, cfg_we = 0;
    logic [4:0]  in_ch = 0;
    logic [7:0]  in_byte = 0, rx_byte = 0;
    logic [2:0]  cfg_addr = 0;
    logic [23:0] cfg_wdata = 0;
    logic        out_valid;
    logic [4:0]  out_ch;
    logic [7:0]  out_byte, mon_byte;

    always #10 clk = ~clk;

    t1_chan_sub i_t1_chan_sub (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fs(in_fs),
        .in_ch(in_ch), .in_byte(in_byte), .rx_byte(rx_byte),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_ch(out_ch), .out_byte(out_byte),
        .mon_byte(mon_byte)
    );

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference model state
    logic [7:0]  sh_idle = 0, ac_idle = 0;
    logic [23:0] sh_sel = 0, ac_sel = 0, sh_xp = 0, ac_xp = 0;
    logic        sh_loop = 0, ac_loop = 0;
    int          m_sel = 0;
    logic [7:0]  m_mon = 0;
    logic        e_valid = 0;
    logic [4:0]  e_ch = 0;
    logic [7:0]  e_byte = 0;

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic step(logic v, logic fs, int ch, logic [7:0] d, logic [7:0] rx,
                        logic we, int addr, logic [23:0] wd);
        logic [7:0]  b, e_idle;
        logic [23:0] e_sel, e_xp;
        logic        e_loop, hit, xp;
        @(negedge clk);
        chk(cur_req, "out_valid (R2)", out_valid, e_valid);
        if (e_valid) begin
            chk(cur_req, "out_ch (R2)", out_ch, e_ch);
            chk(cur_req, "out_byte", out_byte, e_byte);
        end
        chk("R9", "mon_byte", mon_byte, m_mon);
        in_valid = v; in_fs = fs; in_ch = 5'(ch); in_byte = d; rx_byte = rx;
        cfg_we = we; cfg_addr = 3'(addr); cfg_wdata = wd;
        e_idle = (v && fs) ? sh_idle : ac_idle;
        e_sel  = (v && fs) ? sh_sel  : ac_sel;
        e_xp   = (v && fs) ? sh_xp   : ac_xp;
        e_loop = (v && fs) ? sh_loop : ac_loop;
        hit = (ch < 24) && e_sel[ch % 24];
        xp  = (ch < 24) && e_xp[ch % 24];
        b = hit ? (e_loop ? rx : e_idle) : d;
        if (b == 8'h00 && !xp) b = 8'h02;
        e_valid = v; e_ch = 5'(ch); e_byte = b;
        if (v && fs) begin
            ac_idle = sh_idle; ac_sel = sh_sel; ac_xp = sh_xp; ac_loop = sh_loop;
        end
        if (v && ch == m_sel) m_mon = rx;
        if (we) begin
            if (addr == 0) sh_idle = wd[7:0];
            if (addr == 1) sh_sel  = wd;
            if (addr == 2) sh_xp   = wd;
            if (addr == 3) sh_loop = wd[0];
            if (addr == 4) m_sel   = int'(wd[4:0]);
        end
    endtask

    task automatic wr(int addr, logic [23:0] wd);
        step(0, 0, 0, 8'h00, 8'h00, 1, addr, wd);
    endtask

    task automatic frame(logic [7:0] base, logic [7:0] rxbase, int zch,
                         int wr_at, int wr_addr, logic [23:0] wr_data);
        for (int c = 0; c < 24; c++)
            step(1, c == 0, c, (c == zch) ? 8'h00 : 8'(base + 8'(c)),
                 (c == zch) ? 8'h00 : 8'(rxbase + 8'(c)),
                 c == wr_at, wr_addr, wr_data);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        step(0, 0, 0, 0, 0, 0, 0, 0);           // reset state
        frame(8'h40, 8'h80, 3, -1, 0, 0);       // default: pass-through, ch3 stuffed
        cur_req = "R3";
        frame(8'hA0, 8'h10, 7, -1, 0, 0);
        cur_req = "R4";
        wr(0, 24'h00007F);
        wr(1, 24'h800421);                      // channels 0,5,10,23
        frame(8'h20, 8'h30, 5, -1, 0, 0);
        frame(8'h21, 8'h31, 6, -1, 0, 0);
        cur_req = "R8";
        frame(8'h22, 8'h32, 9, 4, 0, 24'h000055); // mid-frame idle change
        frame(8'h23, 8'h33, 9, -1, 0, 0);
        cur_req = "R6";
        wr(0, 24'h000000);                      // zero idle code, stuffed
        frame(8'h24, 8'h34, 11, -1, 0, 0);
        cur_req = "R7";
        wr(2, 24'h000821);                      // transparent 0,5,11
        frame(8'h25, 8'h35, 11, -1, 0, 0);
        cur_req = "R5";
        wr(3, 24'h000001);
        wr(4, 24'h000005);
        frame(8'h50, 8'h90, 10, -1, 0, 0);      // loopback zero on ch10 stuffed
        cur_req = "R9";
        wr(4, 24'h000011);
        frame(8'h51, 8'hC0, 2, -1, 0, 0);
        cur_req = "R10";
        step(1, 0, 25, 8'h00, 8'h44, 0, 0, 0);
        step(1, 0, 30, 8'h9C, 8'h44, 0, 0, 0);
        cur_req = "R11";
        wr(5, 24'hFFFFFF);
        wr(6, 24'h000000);
        wr(7, 24'h000000);
        frame(8'h60, 8'hD0, 4, -1, 0, 0);
        cur_req = "R2";
        step(1, 1, 0, 8'h11, 8'h22, 0, 0, 0);
        step(0, 0, 1, 8'h33, 8'h44, 0, 0, 0);
        step(1, 0, 23, 8'h00, 8'h00, 0, 0, 0);
        step(0, 0, 0, 8'h00, 8'h00, 0, 0, 0);
        step(0, 0, 0, 8'h00, 8'h00, 0, 0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule